// File: doc/BRIEF.md
# Management-Interrupt Acceptance Arbiter

This block sits beside a processor core's instruction sequencer and decides, at each instruction boundary, which interrupt the core takes. It keeps a vector of pending request bits, which outside agents set and clear with per-bit strobes. When the sequencer raises its boundary strobe, the arbiter chooses one of three outcomes: enter system management mode, deliver the maskable hardware interrupt, or do nothing. It reports the choice as a registered one-cycle grant pulse.

The management interrupt has the higher priority. The interrupt-enable flag and the interrupt-shadow flag have no effect on it. Only the arbiter's own in-management-mode flag holds it off. That flag is set when an entry is granted and cleared when the core signals that it has resumed. The maskable interrupt obeys the enable and shadow flags. The arbiter does not clear its pending bit: the interrupt controller that raised the bit clears it.

Top module: `smi_arbiter`

## Requirements
- R1: A synchronous active-high reset clears every pending bit, the in-mode flag and both grant outputs. Reset takes priority over set strobes that arrive in the same cycle.
- R2: Each pending bit is set by its set strobe and cleared by its clear strobe, and the change appears one cycle later. When both strobes are high for the same bit, set wins.
- R3: With the boundary strobe low, neither grant is issued and the arbiter changes no pending bit and not the in-mode flag.
- R4: Suppose the boundary strobe is high, the management bit (bit 6, mask 0x40) is pending and the core is not in management mode. In the next cycle the entry grant is 1, bit 6 is cleared and the in-mode flag is 1.
- R5: Entry does not depend on the interrupt-enable or interrupt-shadow flags.
- R6: While the in-mode flag is 1, a pending management bit is not accepted and stays pending.
- R7: In a decision that grants entry, no hardware-interrupt grant is issued, even when one would otherwise qualify.
- R8: The hardware-interrupt grant is 1 in the cycle after a boundary cycle in which the hardware bit (bit 1, mask 0x02) is pending, enable is 1, shadow is 0 and no entry is granted. Otherwise it is 0.
- R9: A hardware-interrupt grant leaves the hardware pending bit set.
- R10: A resume strobe clears the in-mode flag one cycle later, and a management bit held pending is then accepted at the next boundary.
- R11: Each grant lasts one cycle per qualifying boundary cycle. An entry grant is followed by a cycle with the entry grant at 0 even if the boundary strobe stays high.
- R12: A set strobe on the management bit in the same cycle that the bit is accepted leaves the bit pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe; arbitration happens only when it is high |
| req_set_i | input | NUM_REQ | Per-bit set strobes for the pending vector |
| req_clr_i | input | NUM_REQ | Per-bit clear strobes for the pending vector |
| int_en_i | input | 1 | Core interrupt-enable flag |
| int_shadow_i | input | 1 | Interrupt-shadow (inhibit) flag |
| smm_resume_i | input | 1 | Core has left management mode |
| pend_o | output | NUM_REQ | Pending request vector |
| in_smm_o | output | 1 | In-management-mode flag |
| smm_grant_o | output | 1 | One-cycle management-mode entry grant |
| irq_grant_o | output | 1 | One-cycle hardware-interrupt grant |

## Verification
The bench has management and hardware requests pending together while enable is high and shadow is low. This catches an arbiter that evaluates the two in parallel and pulses both grants. It drives entry with enable low and shadow high, which exposes a design that gates the management interrupt with the maskable-interrupt conditions. It holds a management request through a long stretch in management mode with the boundary strobe high; a design that ignores its own mode flag would re-enter there. It sets the management bit in the same cycle the bit is accepted; a design that lets the acceptance clear win would lose that request. It also confirms that a hardware grant leaves its pending bit set, so an arbiter that consumed the bit would show zero afterwards.

// File: rtl/smi_arb_pkg.sv
package smi_arb_pkg;
   // outcome of one arbitration decision
   typedef enum logic [1:0] {
      DEC_NONE = 2'd0,
      DEC_SMM  = 2'd1,
      DEC_IRQ  = 2'd2
   } dec_e;
endpackage

// File: rtl/smi_pend_bits.sv
module smi_pend_bits #(
   parameter int NUM_REQ = 8,
   parameter int SMI_BIT = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_REQ-1:0] set_i,
   input  logic [NUM_REQ-1:0] clr_i,
   input  logic               smm_accept_i,
   output logic [NUM_REQ-1:0] pend_o
);
   for (genvar b = 0; b < NUM_REQ; b++) begin : g_bit
      logic drop;
      if (b == SMI_BIT) begin : g_smi
         assign drop = clr_i[b] | smm_accept_i;
      end else begin : g_plain
         assign drop = clr_i[b];
      end
      always_ff @(posedge clk) begin
         if (rst)
            pend_o[b] <= 1'b0;
         else if (set_i[b])
            pend_o[b] <= 1'b1;
         else if (drop)
            pend_o[b] <= 1'b0;
      end
   end
endmodule

// File: rtl/smi_mode_flag.sv
module smi_mode_flag (
   input  logic clk,
   input  logic rst,
   input  logic enter_i,
   input  logic resume_i,
   output logic in_smm_o
);
   always_ff @(posedge clk) begin
      if (rst)
         in_smm_o <= 1'b0;
      else if (enter_i)
         in_smm_o <= 1'b1;
      else if (resume_i)
         in_smm_o <= 1'b0;
   end
endmodule

// File: rtl/smi_decide.sv
module smi_decide
   import smi_arb_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic boundary_i,
   input  logic smi_pend_i,
   input  logic hw_pend_i,
   input  logic int_en_i,
   input  logic int_shadow_i,
   input  logic in_smm_i,
   output logic smm_accept_o,
   output logic smm_grant_o,
   output logic irq_grant_o
);
   dec_e dec;

   always_comb begin
      dec = DEC_NONE;
      if (boundary_i) begin
         if (smi_pend_i && !in_smm_i)
            dec = DEC_SMM;
         else if (hw_pend_i && int_en_i && !int_shadow_i)
            dec = DEC_IRQ;
      end
   end

   assign smm_accept_o = (dec == DEC_SMM);

   always_ff @(posedge clk) begin
      if (rst) begin
         smm_grant_o <= 1'b0;
         irq_grant_o <= 1'b0;
      end else begin
         smm_grant_o <= (dec == DEC_SMM);
         irq_grant_o <= (dec == DEC_IRQ);
      end
   end
endmodule

// File: rtl/smi_arbiter.sv
module smi_arbiter #(
   parameter int NUM_REQ = 8,
   parameter int SMI_BIT = 6,
   parameter int HW_BIT  = 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               boundary_i,
   input  logic [NUM_REQ-1:0] req_set_i,
   input  logic [NUM_REQ-1:0] req_clr_i,
   input  logic               int_en_i,
   input  logic               int_shadow_i,
   input  logic               smm_resume_i,
   output logic [NUM_REQ-1:0] pend_o,
   output logic               in_smm_o,
   output logic               smm_grant_o,
   output logic               irq_grant_o
);
   // elaboration-time configuration checks
   if (SMI_BIT == HW_BIT) begin : g_bad_overlap
      $error("smi_arbiter: SMI_BIT and HW_BIT must differ");
   end
   if (SMI_BIT >= NUM_REQ || HW_BIT >= NUM_REQ) begin : g_bad_range
      $error("smi_arbiter: request bit outside the pending vector");
   end

   logic smm_accept;

   smi_pend_bits #(.NUM_REQ(NUM_REQ), .SMI_BIT(SMI_BIT)) u_pend (
      .clk          (clk),
      .rst          (rst),
      .set_i        (req_set_i),
      .clr_i        (req_clr_i),
      .smm_accept_i (smm_accept),
      .pend_o       (pend_o)
   );

   smi_mode_flag u_mode (
      .clk      (clk),
      .rst      (rst),
      .enter_i  (smm_accept),
      .resume_i (smm_resume_i),
      .in_smm_o (in_smm_o)
   );

   smi_decide u_dec (
      .clk          (clk),
      .rst          (rst),
      .boundary_i   (boundary_i),
      .smi_pend_i   (pend_o[SMI_BIT]),
      .hw_pend_i    (pend_o[HW_BIT]),
      .int_en_i     (int_en_i),
      .int_shadow_i (int_shadow_i),
      .in_smm_i     (in_smm_o),
      .smm_accept_o (smm_accept),
      .smm_grant_o  (smm_grant_o),
      .irq_grant_o  (irq_grant_o)
   );
endmodule

// File: rtl/smi_arbiter_chk.sv
module smi_arbiter_chk #(
   parameter int NUM_REQ = 8,
   parameter int SMI_BIT = 6,
   parameter int HW_BIT  = 1
) (
   input logic               clk,
   input logic               rst,
   input logic               boundary_i,
   input logic [NUM_REQ-1:0] req_clr_i,
   input logic               int_en_i,
   input logic               int_shadow_i,
   input logic               smm_resume_i,
   input logic [NUM_REQ-1:0] pend_o,
   input logic               in_smm_o,
   input logic               smm_grant_o,
   input logic               irq_grant_o
);
   // R3
   grant_needs_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      (smm_grant_o || irq_grant_o) |-> $past(boundary_i));
   // R7
   grant_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      !(smm_grant_o && irq_grant_o));
   // R4
   smm_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (boundary_i && pend_o[SMI_BIT] && !in_smm_o) |=> (smm_grant_o && in_smm_o));
   // R6
   smm_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_o[SMI_BIT] && in_smm_o && !req_clr_i[SMI_BIT]) |=> pend_o[SMI_BIT]);
   // R8
   irq_cond_chk: assert property (@(posedge clk) disable iff (rst)
      irq_grant_o |-> $past(pend_o[HW_BIT] && int_en_i && !int_shadow_i));
   // R9
   irq_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (pend_o[HW_BIT] && !req_clr_i[HW_BIT]) |=> pend_o[HW_BIT]);
   // R10
   resume_chk: assert property (@(posedge clk) disable iff (rst)
      (smm_resume_i && in_smm_o) |=> !in_smm_o);
endmodule

bind smi_arbiter smi_arbiter_chk #(.NUM_REQ(NUM_REQ), .SMI_BIT(SMI_BIT), .HW_BIT(HW_BIT)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .boundary_i   (boundary_i),
   .req_clr_i    (req_clr_i),
   .int_en_i     (int_en_i),
   .int_shadow_i (int_shadow_i),
   .smm_resume_i (smm_resume_i),
   .pend_o       (pend_o),
   .in_smm_o     (in_smm_o),
   .smm_grant_o  (smm_grant_o),
   .irq_grant_o  (irq_grant_o)
);

// File: tb/smi_arbiter_tb.sv
module smi_arbiter_tb;
   localparam int N = 8;
   localparam logic [N-1:0] SMI = 8'h40;
   localparam logic [N-1:0] HW  = 8'h02;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic boundary = 1'b0;
   logic [N-1:0] rset = '0;
   logic [N-1:0] rclr = '0;
   logic ie = 1'b0;
   logic shadow = 1'b0;
   logic resume = 1'b0;
   logic [N-1:0] pend;
   logic in_smm, g_smm, g_irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   smi_arbiter #(.NUM_REQ(N), .SMI_BIT(6), .HW_BIT(1)) u_dut (
      .clk(clk), .rst(rst), .boundary_i(boundary), .req_set_i(rset),
      .req_clr_i(rclr), .int_en_i(ie), .int_shadow_i(shadow),
      .smm_resume_i(resume), .pend_o(pend), .in_smm_o(in_smm),
      .smm_grant_o(g_smm), .irq_grant_o(g_irq)
   );

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic leave_smm();
      resume = 1'b1; tick(); resume = 1'b0;
   endtask

   task automatic t_reset();
      rset = SMI | HW;
      tick(); tick();
      chk("R1 pend", pend, 0);
      chk("R1 in_smm", in_smm, 0);
      chk("R1 grants", {g_smm, g_irq}, 0);
      rset = '0;
      rst = 1'b0;
      tick();
      chk("R1 pend after release", pend, 0);
   endtask

   task automatic t_set_clear();
      rset = 8'h81; tick(); rset = '0;
      chk("R2 set", pend, 8'h81);
      rset = 8'h04; rclr = 8'h05; tick(); rset = '0; rclr = '0;
      chk("R2 set wins", pend, 8'h84);
      rclr = 8'h84; tick(); rclr = '0;
      chk("R2 clear", pend, 0);
   endtask

   task automatic t_no_boundary();
      ie = 1'b1; shadow = 1'b0;
      rset = SMI | HW; tick(); rset = '0;
      for (int i = 0; i < 4; i++) begin
         tick();
         chk("R3 no grant", {g_smm, g_irq}, 0);
      end
      chk("R3 pend kept", pend, SMI | HW);
      chk("R3 mode kept", in_smm, 0);
   endtask

   task automatic t_entry_priority();
      // SMI and HW both pending, HW qualifies
      boundary = 1'b1; tick(); boundary = 1'b0;
      chk("R4 entry grant", g_smm, 1);
      chk("R7 no irq on entry", g_irq, 0);
      chk("R4 smi bit cleared", pend, HW);
      chk("R4 in_smm", in_smm, 1);
      tick();
      chk("R11 pulse ends", g_smm, 0);
      leave_smm();
      chk("R10 resume clears mode", in_smm, 0);
      rclr = HW; tick(); rclr = '0;
   endtask

   task automatic t_entry_masked();
      ie = 1'b0; shadow = 1'b1;
      rset = SMI; tick(); rset = '0;
      boundary = 1'b1; tick();
      chk("R5 entry while masked", g_smm, 1);
      tick(); boundary = 1'b0;
      chk("R11 single entry pulse", g_smm, 0);
      leave_smm();
      ie = 1'b1; shadow = 1'b0;
   endtask

   task automatic t_hold_resume();
      rset = SMI; tick(); rset = '0;
      boundary = 1'b1; tick(); boundary = 1'b0;
      chk("R4 enter", in_smm, 1);
      rset = SMI | HW; tick(); rset = '0;
      boundary = 1'b1;
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R6 no re-entry", g_smm, 0);
         chk("R8 irq inside mode", g_irq, 1);
      end
      boundary = 1'b0;
      chk("R6 smi still pending", pend & SMI, SMI);
      rclr = HW; tick(); rclr = '0;
      leave_smm();
      chk("R10 mode cleared", in_smm, 0);
      boundary = 1'b1; tick(); boundary = 1'b0;
      chk("R10 held smi accepted", g_smm, 1);
      leave_smm();
   endtask

   task automatic t_hw();
      rset = HW; tick(); rset = '0;
      ie = 1'b0; shadow = 1'b0;
      boundary = 1'b1; tick();
      chk("R8 disabled", g_irq, 0);
      ie = 1'b1; shadow = 1'b1; tick();
      chk("R8 shadowed", g_irq, 0);
      shadow = 1'b0; tick(); boundary = 1'b0;
      chk("R8 granted", g_irq, 1);
      chk("R9 hw bit kept", pend, HW);
      tick();
      chk("R11 irq pulse ends", g_irq, 0);
      rclr = HW; tick(); rclr = '0;
      boundary = 1'b1; tick(); boundary = 1'b0;
      chk("R8 nothing pending", g_irq, 0);
   endtask

   task automatic t_set_on_accept();
      rset = SMI; tick();
      boundary = 1'b1; tick(); boundary = 1'b0; rset = '0;
      chk("R12 accepted", g_smm, 1);
      chk("R12 bit stays pending", pend & SMI, SMI);
      chk("R12 in mode", in_smm, 1);
      leave_smm();
      rclr = SMI; tick(); rclr = '0;
   endtask

   task automatic t_midrun_reset();
      rset = SMI | HW; tick(); rset = '0;
      boundary = 1'b1; tick(); boundary = 1'b0;
      rst = 1'b1; tick(); rst = 1'b0;
      chk("R1 reset clears pend", pend, 0);
      chk("R1 reset clears mode", in_smm, 0);
   endtask

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      tick();
      t_reset();
      t_set_clear();
      t_no_boundary();
      t_entry_priority();
      t_entry_masked();
      t_hold_resume();
      t_hw();
      t_set_on_accept();
      t_midrun_reset();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule